// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block brings a two-wire serial bus back to a usable state when a target device has been left stuck partway through a byte and is holding the data line low. On a single-cycle request it releases both lines and then toggles the clock line a fixed nine times. While it does this it watches the data line after every clock rise and notes whether the data line was ever seen high. Clocking always runs the full count, so any target that is still shifting ends up aligned to a byte boundary.

If the data line was seen high, the block produces a START and then a STOP while the clock line stays released the whole time. It then waits for the bus-free interval before it reports completion. If the data line was never seen high, the bus is taken to be wedged and completion is reported at once with a failure flag. Both lines are open-drain: an enable output of 1 pulls the line low, and 0 releases it to its pull-up. All timing is counted in pulses of a one-microsecond tick input. Each clock release waits for a target that holds the clock low (clock stretching), up to a timeout.

Top module: `bus_unwedge`

## Requirements
- R1: After reset both drive enables are 0 (lines released), `busy` is 0, and `done`, `fail`, `not_rest` and `scl_stuck` are 0.
- R2: A `recover` pulse while idle raises `busy` on the next cycle. A `recover` pulse while busy has no effect. Each sequence ends with exactly one single-cycle `done` pulse, and `busy` is 0 in the cycle of that pulse.
- R3: Every sequence asserts `scl_oe` in exactly nine separate low phases, no more and no fewer.
- R4: Each clock low phase lasts exactly LOW_US tick pulses (default 3).
- R5: All nine clock phases are issued even when the data line is high from the first sample onward.
- R6: If the data line was low at all nine samples, `sda_oe` is never asserted, and `done` comes with `fail` = 1.
- R7: If the data line was high at one sample or more, `sda_oe` is asserted exactly once, for one tick period. During that time `scl_oe` stays 0 and the clock line stays high.
- R8: If the data line was seen high, `not_rest` is 1 at `done` exactly when either line was low at the check after the ninth clock rise. Otherwise `not_rest` is 0.
- R9: After `sda_oe` is released, exactly BUF_US tick pulses (default 60) pass before `done`.
- R10: After each clock release, the block waits while a target holds the clock line low. If the line is still low after STRETCH_US ticks (default 1000), the block samples anyway, carries on, and reports `scl_stuck` = 1 with `done`. A short stretch does not set the flag.
- R11: On a sequence in which the data line was seen high, `fail` is 0 at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| recover | input | 1 | Starts a recovery sequence when idle |
| scl_in | input | 1 | Clock line level as seen on the pin |
| sda_in | input | 1 | Data line level as seen on the pin |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Data line never seen high; valid with done |
| not_rest | output | 1 | A line was low at the check; valid with done |
| scl_stuck | output | 1 | A clock stretch timed out; valid with done |

## Verification
The assertions assume that `tick_us` is a single-cycle pulse spaced several clocks apart. They also assume the pin inputs are the wired levels of open-drain lines, so a line reads low whenever this block or a target pulls it. The bench models both lines as wired-AND of the block's enables and a target model. It issues ticks every four clocks and changes the target's pulls only between clock phases, well clear of the two-stage input synchronizer. The timeout case holds the clock line low through the whole sequence, and the bench measures the phase durations in ticks at the output enables.

// File: rtl/unwedge_pkg.sv
package unwedge_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REL,
        S_LOW,
        S_RISE,
        S_CHECK,
        S_SETUP,
        S_HOLD,
        S_BUF
    } unwedge_st_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/tick_count.sv
module tick_count #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                      cnt_d = '0;
        else if (tick && cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bus_unwedge.sv
module bus_unwedge
    import unwedge_pkg::*;
#(
    parameter int PULSES     = 9,
    parameter int LOW_US     = 3,
    parameter int STRETCH_US = 1000,
    parameter int SETUP_US   = 1,
    parameter int HOLD_US    = 1,
    parameter int BUF_US     = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic recover,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic fail,
    output logic not_rest,
    output logic scl_stuck
);
    localparam int MAX_WAIT = (STRETCH_US > BUF_US) ? STRETCH_US : BUF_US;
    localparam int CW = $clog2(MAX_WAIT + 1);
    localparam int PW = $clog2(PULSES + 1);

    typedef struct packed {
        unwedge_st_e   st;
        logic [PW-1:0] clks;
        logic          seen;
        logic          bad;
        logic          stuck;
        logic          fail;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;
    logic [1:0] lines_s;
    logic scl_s, sda_s;
    logic [CW-1:0] cnt;
    logic timer_clr;

    line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    tick_count #(.W(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr), .tick(tick_us), .cnt(cnt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (recover) begin
                    r_d.st    = S_REL;
                    r_d.clks  = '0;
                    r_d.seen  = 1'b0;
                    r_d.bad   = 1'b0;
                    r_d.stuck = 1'b0;
                    r_d.fail  = 1'b0;
                end
            end
            S_REL: begin
                if (tick_us) r_d.st = S_LOW;
            end
            S_LOW: begin
                if (tick_us && cnt == CW'(LOW_US - 1)) r_d.st = S_RISE;
            end
            S_RISE: begin
                if (tick_us && (scl_s || cnt == CW'(STRETCH_US - 1))) begin
                    if (!scl_s) r_d.stuck = 1'b1;
                    r_d.seen = r_q.seen | sda_s;
                    r_d.clks = r_q.clks + 1'b1;
                    r_d.st   = (r_q.clks == PW'(PULSES - 1)) ? S_CHECK : S_LOW;
                end
            end
            S_CHECK: begin
                if (!r_q.seen) begin
                    r_d.fail = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.bad = !(scl_s && sda_s);
                    r_d.st  = S_SETUP;
                end
            end
            S_SETUP: begin
                if (tick_us && cnt == CW'(SETUP_US - 1)) r_d.st = S_HOLD;
            end
            S_HOLD: begin
                if (tick_us && cnt == CW'(HOLD_US - 1)) r_d.st = S_BUF;
            end
            S_BUF: begin
                if (tick_us && cnt == CW'(BUF_US - 1)) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    assign timer_clr = (r_d.st != r_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_IDLE, clks: '0, default: 1'b0};
        else        r_q <= r_d;
    end

    assign scl_oe    = (r_q.st == S_LOW);
    assign sda_oe    = (r_q.st == S_HOLD);
    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign not_rest  = r_q.bad;
    assign scl_stuck = r_q.stuck;

    // R1: released lines whenever idle
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R2: done is a lone pulse that coincides with busy dropping
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $fell(busy)));

    // R3: the pulse counter never passes the clock count
    p_clk_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.clks <= PW'(PULSES));

    // R6: data is only pulled after a high sample
    p_pull_needs_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> r_q.seen);

    // R7: clock is released throughout the START/STOP
    p_scl_high_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> !scl_oe);

    // R11: a sequence with a high sample never ends as failed
    p_no_fail_after_seen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.seen) |-> !fail);
endmodule

// File: tb/bus_unwedge_test.sv
module bus_unwedge_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_CYC   = 4;
    localparam int LOW_US     = 3;
    localparam int STRETCH_US = 1000;
    localparam int BUF_US     = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic recover = 1'b0;
    logic slave_scl_low = 1'b0;
    logic slave_sda_low = 1'b0;
    logic scl_oe, sda_oe, busy, done, fail, not_rest, scl_stuck;
    logic scl_line, sda_line;

    int checks = 0;
    int errors = 0;

    assign scl_line = !(scl_oe || slave_scl_low);
    assign sda_line = !(sda_oe || slave_sda_low);

    bus_unwedge #(.LOW_US(LOW_US), .STRETCH_US(STRETCH_US), .BUF_US(BUF_US)) uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .recover(recover),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
        .fail(fail), .not_rest(not_rest), .scl_stuck(scl_stuck)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        int tc;
        tc = 0;
        forever begin
            @(posedge clk);
            #1;
            tick_us = (tc == TICK_CYC - 1);
            tc = (tc == TICK_CYC - 1) ? 0 : tc + 1;
        end
    end

    // port monitor
    logic mon_clr = 1'b0;
    int falls, low_bad, cur_low, sda_pulls, sda_ticks, viol_oe, viol_line;
    int buf_ticks, dones;
    logic post_hold, prev_scl_oe, prev_sda_oe;
    logic last_fail, last_rest, last_stuck;

    always @(negedge clk) begin
        if (mon_clr) begin
            falls = 0; low_bad = 0; cur_low = 0; sda_pulls = 0; sda_ticks = 0;
            viol_oe = 0; viol_line = 0; buf_ticks = 0; dones = 0;
            post_hold = 1'b0; prev_scl_oe = 1'b0; prev_sda_oe = 1'b0;
        end else begin
            if (scl_oe && !prev_scl_oe) begin falls++; cur_low = 0; end
            if (scl_oe && tick_us) cur_low++;
            if (!scl_oe && prev_scl_oe && cur_low != LOW_US) low_bad++;
            if (sda_oe && !prev_sda_oe) sda_pulls++;
            if (sda_oe && tick_us) sda_ticks++;
            if (sda_oe && scl_oe) viol_oe++;
            if (sda_oe && !scl_line) viol_line++;
            if (!sda_oe && prev_sda_oe) begin post_hold = 1'b1; buf_ticks = 0; end
            if (post_hold && tick_us) buf_ticks++;
            if (done) begin
                dones++; post_hold = 1'b0;
                last_fail = fail; last_rest = not_rest; last_stuck = scl_stuck;
            end
            prev_scl_oe = scl_oe;
            prev_sda_oe = sda_oe;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1 mon_clr = 1'b1;
        @(posedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic pulse_recover();
        @(posedge clk); #1 recover = 1'b1;
        @(posedge clk); #1 recover = 1'b0;
    endtask

    task automatic wait_done();
        while (dones == 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!scl_oe && !sda_oe, "R1 enables", {scl_oe, sda_oe}, 0);
        check(!busy && !done, "R1 busy/done", {busy, done}, 0);
        check(!fail && !not_rest && !scl_stuck, "R1 flags", {fail, not_rest, scl_stuck}, 0);
    endtask

    task automatic t_idle_bus();
        slave_sda_low = 1'b0;
        clear_mon();
        @(posedge clk); #1 recover = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R2 busy before edge", busy, 0);
        @(posedge clk); #1 recover = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R2 busy after request", busy, 1);
        wait_done();
        check(falls == 9, "R3 clock phases idle bus", falls, 9);
        check(low_bad == 0, "R4 low phase length", low_bad, 0);
        check(falls == 9, "R5 full count with SDA high", falls, 9);
        check(sda_pulls == 1, "R7 one data pull", sda_pulls, 1);
        check(sda_ticks == 1, "R7 data pull length", sda_ticks, 1);
        check(viol_oe == 0 && viol_line == 0, "R7 SCL high during pull", viol_oe + viol_line, 0);
        check(buf_ticks == BUF_US, "R9 bus-free wait", buf_ticks, BUF_US);
        check(last_fail == 1'b0, "R11 fail clear", last_fail, 0);
        check(last_rest == 1'b0, "R8 lines at rest", last_rest, 0);
        check(last_stuck == 1'b0, "R10 no stuck", last_stuck, 0);
        check(dones == 1, "R2 one done", dones, 1);
    endtask

    task automatic t_wedged();
        slave_sda_low = 1'b1;
        clear_mon();
        pulse_recover();
        wait_done();
        check(falls == 9, "R3 clock phases wedged", falls, 9);
        check(sda_pulls == 0, "R6 no data pull", sda_pulls, 0);
        check(last_fail == 1'b1, "R6 fail set", last_fail, 1);
        slave_sda_low = 1'b0;
    endtask

    task automatic t_not_rest();
        slave_sda_low = 1'b1;
        clear_mon();
        pulse_recover();
        while (falls < 4) @(negedge clk);
        @(posedge clk); #1 slave_sda_low = 1'b0;
        while (falls < 5) @(negedge clk);
        @(posedge clk); #1 slave_sda_low = 1'b1;
        wait_done();
        check(falls == 9, "R3 clock phases mid release", falls, 9);
        check(sda_pulls == 1, "R7 pull after one high sample", sda_pulls, 1);
        check(last_rest == 1'b1, "R8 data low at check", last_rest, 1);
        check(last_fail == 1'b0, "R11 fail clear on single high", last_fail, 0);
        slave_sda_low = 1'b0;
    endtask

    task automatic t_ignore_busy();
        clear_mon();
        pulse_recover();
        while (falls < 3) @(negedge clk);
        pulse_recover();
        while (sda_pulls < 1) @(negedge clk);
        pulse_recover();
        wait_done();
        repeat (200) @(negedge clk);
        check(falls == 9, "R2 request while busy ignored (phases)", falls, 9);
        check(dones == 1, "R2 request while busy ignored (done)", dones, 1);
        check(busy == 1'b0, "R2 idle after sequence", busy, 0);
    endtask

    task automatic t_short_stretch();
        clear_mon();
        pulse_recover();
        while (falls < 3) @(negedge clk);
        while (scl_oe) @(negedge clk);
        @(posedge clk); #1 slave_scl_low = 1'b1;
        repeat (40) @(posedge clk);
        #1 slave_scl_low = 1'b0;
        wait_done();
        check(falls == 9, "R10 phases with short stretch", falls, 9);
        check(last_stuck == 1'b0, "R10 short stretch no flag", last_stuck, 0);
    endtask

    task automatic t_stuck_clock();
        slave_scl_low = 1'b1;
        clear_mon();
        pulse_recover();
        wait_done();
        check(falls == 9, "R10 phases with stuck clock", falls, 9);
        check(last_stuck == 1'b1, "R10 stuck flag", last_stuck, 1);
        check(last_rest == 1'b1, "R8 clock low at check", last_rest, 1);
        slave_scl_low = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        clear_mon();
        t_reset();
        t_idle_bus();
        t_wedged();
        t_not_rest();
        t_ignore_busy();
        t_short_stretch();
        t_stuck_clock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule